// File: doc/BRIEF.md
# Passive Tag Byte Reader Sequencer

This controller drives a separate bit transmitter and a separate edge-counting receiver. Together they wake a passive tag, find out which kind of tag it is, and copy the tag's memory out one byte at a time. A pulse on `start` begins a run. The controller first powers the carrier and does one identification handshake. It then drops the carrier. After that it repeats one power cycle for each byte. Each power cycle does the same steps:

- power the carrier
- let the tag charge
- run the fixed wake and acknowledge exchange, and confirm the tag type is unchanged
- send a masked read command
- de-mask the 8-bit answer and write it to the byte write port
- switch the carrier off so the tag resets

All waits are counted in pulses of the `tick` strobe, so the caller sets real time through the tick rate and the tick-count parameters. The two supported tag types are parameters. Each type has its own type code, memory size, command length and response mask. A run ends in one of four ways:

- every byte was read (`done_ok`)
- the type changed during a repeat handshake (`tag_removed`)
- the first type was not recognised (`tag_unknown`)
- the abort button stopped the loop; no status flag is raised in this case.

Top module: `tag_read_seq`

## Requirements
- R1: After reset the carrier is off. `busy`, `tx_req`, `rx_req`, `wr_en` and all three status flags are low.
- R2: Every handshake begins with the carrier already on for at least `CHARGE_TICKS` ticks. Its first frame is the 7-bit value 0x55 (`tx_data`=0x55, `tx_bits`=7), sent only while the carrier is on.
- R3: After the wake frame the block requests a 6-bit receive. At least `GAP_TICKS` ticks after that reply ends, it sends the 6-bit value 0x19. Transmit and receive requests are never active together.
- R4: The tag type is `rx_data[5:0]` XOR 0x26, taken from the 6-bit reply. If the first type matches neither `TYPE_A` nor `TYPE_B`, the run ends with `tag_unknown` high, no byte written and the carrier off.
- R5: The read command for byte n is 0x57 XOR (n shifted left by one). It is sent with `CMD_BITS_A` or `CMD_BITS_B` bits according to the type, at least `GAP_TICKS` ticks after the acknowledge frame.
- R6: The 8-bit reply to the command for byte n is XORed with `RESP_A` or `RESP_B` and written at address n. Addresses run 0, 1, 2 and upward. After the last address, `done_ok` rises and `busy` falls.
- R7: Each byte is read in its own power cycle. Between cycles the carrier stays off for at least `OFF_TICKS` ticks. A full run of a tag with S bytes therefore sends S+1 wake frames.
- R8: If a repeat handshake returns a type different from the first, the run ends at once. `tag_removed` goes high, the carrier is off, and that byte and every later byte are not read.
- R9: If `abort_btn` is seen while busy, the loop stops at the start of the next power cycle. Bytes already written stay written, no status flag rises, and `busy` falls.
- R10: At most one status flag is high at any time. A new `start` clears all of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Pulse that begins a read run when idle |
| tick | input | 1 | Timing strobe; all waits count these pulses |
| tx_done | input | 1 | Transmitter finished the requested frame |
| rx_done | input | 1 | Receiver finished the requested frame |
| abort_btn | input | 1 | Request to stop the read loop |
| rx_data | input | 8 | Received bits, LSB first in bit 0 |
| tx_req | output | 1 | Transmit request, held until `tx_done` |
| tx_data | output | TXD_W | Frame value to transmit |
| tx_bits | output | 5 | Frame length in bits |
| rx_req | output | 1 | Receive request, held until `rx_done` |
| rx_bits | output | 4 | Number of bits to receive |
| carrier_on | output | 1 | Field carrier enable |
| wr_en | output | 1 | Byte write strobe |
| wr_addr | output | ADDR_W | Byte write address |
| wr_data | output | 8 | De-masked byte |
| busy | output | 1 | A run is in progress |
| done_ok | output | 1 | All bytes of the tag were read |
| tag_removed | output | 1 | Tag type changed during the run |
| tag_unknown | output | 1 | First tag type was not recognised |

## Verification
A wrong stored type or a stale byte index shows up within one power cycle, on the transmit port. It appears as a command with the wrong value or the wrong length, or as an early `tag_removed`. A wrong response mask or a wrong address appears on the very next `wr_en` strobe. A timing counter that is cleared at the wrong moment shortens a charge, gap or carrier-off interval. The bench measures every such interval directly from the port edges, so a short one is caught in the same run.

// File: rtl/tsr_pkg.sv
package tsr_pkg;

   typedef enum logic [3:0] {
      S_IDLE,
      S_CHARGE,
      S_WAKE,
      S_REPLY,
      S_GAP1,
      S_ACK,
      S_GAP2,
      S_CMD,
      S_DATA,
      S_OFF
   } tsr_state_e;

   localparam logic [6:0] WAKE_CODE  = 7'h55;
   localparam logic [4:0] WAKE_BITS  = 5'd7;
   localparam logic [5:0] ACK_CODE   = 6'h19;
   localparam logic [4:0] ACK_BITS   = 5'd6;
   localparam logic [3:0] REPLY_BITS = 4'd6;
   localparam logic [3:0] DATA_BITS  = 4'd8;
   localparam logic [5:0] TYPE_XOR   = 6'h26;
   localparam logic [7:0] CMD_BASE   = 8'h57;

endpackage

// File: rtl/tsr_tick_timer.sv
module tsr_tick_timer #(
   parameter int CNT_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             tick,
   output logic [CNT_W-1:0] cnt
);

   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   generate
      if (CNT_W < 2) begin : g_bad_width
         $error("tsr_tick_timer: CNT_W must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (clr)
         cnt <= '0;
      else if (tick && cnt != CNT_MAX)
         cnt <= cnt + 1'b1;
   end

   // a cleared counter starts from zero on the next cycle
   assert_clear_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $past(clr) |-> (cnt <= CNT_W'(1)))
      else $error("timer not restarted after clear");

endmodule

// File: rtl/tsr_type_decode.sv
module tsr_type_decode #(
   parameter logic [5:0] TYPE_A     = 6'h0D,
   parameter logic [5:0] TYPE_B     = 6'h1D,
   parameter int         SIZE_A     = 256,
   parameter int         SIZE_B     = 1024,
   parameter int         CMD_BITS_A = 9,
   parameter int         CMD_BITS_B = 11,
   parameter logic [7:0] RESP_A     = 8'h52,
   parameter logic [7:0] RESP_B     = 8'hD4,
   parameter int         IDX_W      = 11
) (
   input  logic [5:0]       tag_type,
   output logic             valid,
   output logic [IDX_W-1:0] size,
   output logic [4:0]       cmd_bits,
   output logic [7:0]       resp_mask
);

   generate
      if (TYPE_A == TYPE_B) begin : g_bad_codes
         $error("tsr_type_decode: type codes must differ");
      end
      if (SIZE_A < 1 || SIZE_B < 1) begin : g_bad_size
         $error("tsr_type_decode: sizes must be positive");
      end
      if (CMD_BITS_A < 1 || CMD_BITS_A > 31 || CMD_BITS_B < 1 || CMD_BITS_B > 31) begin : g_bad_bits
         $error("tsr_type_decode: command lengths must be 1..31");
      end
   endgenerate

   always_comb begin
      valid     = 1'b0;
      size      = '0;
      cmd_bits  = '0;
      resp_mask = '0;
      if (tag_type == TYPE_A) begin
         valid     = 1'b1;
         size      = IDX_W'(SIZE_A);
         cmd_bits  = 5'(CMD_BITS_A);
         resp_mask = RESP_A;
      end else if (tag_type == TYPE_B) begin
         valid     = 1'b1;
         size      = IDX_W'(SIZE_B);
         cmd_bits  = 5'(CMD_BITS_B);
         resp_mask = RESP_B;
      end
   end

endmodule

// File: rtl/tag_read_seq.sv
module tag_read_seq #(
   parameter logic [5:0] TYPE_A       = 6'h0D,
   parameter logic [5:0] TYPE_B       = 6'h1D,
   parameter int         SIZE_A       = 256,
   parameter int         SIZE_B       = 1024,
   parameter int         CMD_BITS_A   = 9,
   parameter int         CMD_BITS_B   = 11,
   parameter logic [7:0] RESP_A       = 8'h52,
   parameter logic [7:0] RESP_B       = 8'hD4,
   parameter int         CHARGE_TICKS = 1500,
   parameter int         GAP_TICKS    = 387,
   parameter int         OFF_TICKS    = 1500,
   parameter int         TXD_W        = 16,
   localparam int        MAX_SIZE     = (SIZE_A > SIZE_B) ? SIZE_A : SIZE_B,
   localparam int        ADDR_W       = (MAX_SIZE > 1) ? $clog2(MAX_SIZE) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              tick,
   input  logic              tx_done,
   input  logic              rx_done,
   input  logic              abort_btn,
   input  logic [7:0]        rx_data,
   output logic              tx_req,
   output logic [TXD_W-1:0]  tx_data,
   output logic [4:0]        tx_bits,
   output logic              rx_req,
   output logic [3:0]        rx_bits,
   output logic              carrier_on,
   output logic              wr_en,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [7:0]        wr_data,
   output logic              busy,
   output logic              done_ok,
   output logic              tag_removed,
   output logic              tag_unknown
);
   import tsr_pkg::*;

   localparam int IDX_W  = ADDR_W + 1;
   localparam int T_MAX0 = (CHARGE_TICKS > GAP_TICKS) ? CHARGE_TICKS : GAP_TICKS;
   localparam int T_MAX  = (T_MAX0 > OFF_TICKS) ? T_MAX0 : OFF_TICKS;
   localparam int CNT_W  = $clog2(T_MAX + 1) + 1;

   generate
      if (OFF_TICKS < 1 || CHARGE_TICKS < 1) begin : g_bad_times
         $error("tag_read_seq: charge and off times must be at least one tick");
      end
      if (TXD_W < 8 || TXD_W < IDX_W + 1) begin : g_bad_txd
         $error("tag_read_seq: TXD_W too narrow for the command");
      end
   endgenerate

   tsr_state_e        state;
   logic              ident;
   logic              abort_q;
   logic [5:0]        type_q;
   logic [5:0]        reply_q;
   logic [IDX_W-1:0]  idx;
   logic [CNT_W-1:0]  cnt;
   logic              tmr_clr;
   logic              dec_valid;
   logic [IDX_W-1:0]  dec_size;
   logic [4:0]        dec_bits;
   logic [7:0]        dec_mask;
   logic              charge_hit, gap_hit, off_hit;

   tsr_tick_timer #(.CNT_W(CNT_W)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (tmr_clr),
      .tick  (tick),
      .cnt   (cnt)
   );

   tsr_type_decode #(
      .TYPE_A(TYPE_A), .TYPE_B(TYPE_B), .SIZE_A(SIZE_A), .SIZE_B(SIZE_B),
      .CMD_BITS_A(CMD_BITS_A), .CMD_BITS_B(CMD_BITS_B),
      .RESP_A(RESP_A), .RESP_B(RESP_B), .IDX_W(IDX_W)
   ) u_decode (
      .tag_type  (type_q),
      .valid     (dec_valid),
      .size      (dec_size),
      .cmd_bits  (dec_bits),
      .resp_mask (dec_mask)
   );

   assign charge_hit = (cnt >= CNT_W'(CHARGE_TICKS));
   assign gap_hit    = (cnt >= CNT_W'(GAP_TICKS));
   assign off_hit    = (cnt >= CNT_W'(OFF_TICKS));

   always_comb begin
      tx_req  = 1'b0;
      tx_data = '0;
      tx_bits = '0;
      rx_req  = 1'b0;
      rx_bits = '0;
      unique case (state)
         S_WAKE: begin
            tx_req  = 1'b1;
            tx_data = TXD_W'(WAKE_CODE);
            tx_bits = WAKE_BITS;
         end
         S_ACK: begin
            tx_req  = 1'b1;
            tx_data = TXD_W'(ACK_CODE);
            tx_bits = ACK_BITS;
         end
         S_CMD: begin
            tx_req  = 1'b1;
            tx_data = TXD_W'(CMD_BASE) ^ (TXD_W'(idx) << 1);
            tx_bits = dec_bits;
         end
         S_REPLY: begin
            rx_req  = 1'b1;
            rx_bits = REPLY_BITS;
         end
         S_DATA: begin
            rx_req  = 1'b1;
            rx_bits = DATA_BITS;
         end
         default: ;
      endcase
   end

   assign tmr_clr = (state == S_IDLE && start) || (tx_req && tx_done) ||
                    (rx_req && rx_done) || (state == S_OFF && off_hit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state       <= S_IDLE;
         ident       <= 1'b0;
         abort_q     <= 1'b0;
         type_q      <= '0;
         reply_q     <= '0;
         idx         <= '0;
         carrier_on  <= 1'b0;
         wr_en       <= 1'b0;
         wr_addr     <= '0;
         wr_data     <= '0;
         busy        <= 1'b0;
         done_ok     <= 1'b0;
         tag_removed <= 1'b0;
         tag_unknown <= 1'b0;
      end else begin
         wr_en <= 1'b0;
         if (busy && abort_btn) abort_q <= 1'b1;
         unique case (state)
            S_IDLE: if (start) begin
               busy        <= 1'b1;
               done_ok     <= 1'b0;
               tag_removed <= 1'b0;
               tag_unknown <= 1'b0;
               ident       <= 1'b1;
               idx         <= '0;
               abort_q     <= 1'b0;
               carrier_on  <= 1'b1;
               state       <= S_CHARGE;
            end
            S_CHARGE: if (charge_hit) state <= S_WAKE;
            S_WAKE:   if (tx_done) state <= S_REPLY;
            S_REPLY:  if (rx_done) begin
               reply_q <= rx_data[5:0] ^ TYPE_XOR;
               state   <= S_GAP1;
            end
            S_GAP1:   if (gap_hit) state <= S_ACK;
            S_ACK:    if (tx_done) begin
               if (ident) begin
                  type_q     <= reply_q;
                  carrier_on <= 1'b0;
                  state      <= S_OFF;
               end else if (reply_q != type_q) begin
                  tag_removed <= 1'b1;
                  carrier_on  <= 1'b0;
                  busy        <= 1'b0;
                  state       <= S_IDLE;
               end else begin
                  state <= S_GAP2;
               end
            end
            S_GAP2:   if (gap_hit) state <= S_CMD;
            S_CMD:    if (tx_done) state <= S_DATA;
            S_DATA:   if (rx_done) begin
               wr_en      <= 1'b1;
               wr_addr    <= idx[ADDR_W-1:0];
               wr_data    <= rx_data ^ dec_mask;
               idx        <= idx + 1'b1;
               carrier_on <= 1'b0;
               state      <= S_OFF;
            end
            S_OFF:    if (off_hit) begin
               if (ident && !dec_valid) begin
                  tag_unknown <= 1'b1;
                  busy        <= 1'b0;
                  state       <= S_IDLE;
               end else if (!ident && idx == dec_size) begin
                  done_ok <= 1'b1;
                  busy    <= 1'b0;
                  state   <= S_IDLE;
               end else if (abort_q || abort_btn) begin
                  busy  <= 1'b0;
                  state <= S_IDLE;
               end else begin
                  ident      <= 1'b0;
                  carrier_on <= 1'b1;
                  state      <= S_CHARGE;
               end
            end
            default: state <= S_IDLE;
         endcase
      end
   end

   assert_tx_powered_R2: assert property (@(posedge clk) disable iff (!rst_n)
      tx_req |-> carrier_on)
      else $error("transmit requested with carrier off");

   assert_no_overlap_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !(tx_req && rx_req))
      else $error("transmit and receive requested together");

   assert_unknown_ends_R4: assert property (@(posedge clk) disable iff (!rst_n)
      tag_unknown |-> (!busy && !carrier_on))
      else $error("unknown tag left the run active");

   assert_wr_in_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (IDX_W'(wr_addr) < dec_size))
      else $error("write beyond tag size");

   assert_off_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(carrier_on) |=> !carrier_on)
      else $error("carrier-off interval too short");

   assert_removed_ends_R8: assert property (@(posedge clk) disable iff (!rst_n)
      tag_removed |-> (!busy && !carrier_on))
      else $error("removed tag left the run active");

   assert_one_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({done_ok, tag_removed, tag_unknown}))
      else $error("more than one status flag set");

endmodule

// File: tb/tag_read_seq_tb.sv
module tag_read_seq_tb;

   localparam logic [5:0] T_A   = 6'h0D;
   localparam logic [5:0] T_B   = 6'h1D;
   localparam int  SZ_A   = 4;
   localparam int  SZ_B   = 6;
   localparam int  CB_A   = 9;
   localparam int  CB_B   = 11;
   localparam logic [7:0] RM_A = 8'h52;
   localparam logic [7:0] RM_B = 8'hD4;
   localparam int  CHG    = 20;
   localparam int  GAP    = 12;
   localparam int  OFF    = 15;
   localparam int  TXW    = 16;
   localparam int  AW     = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0, tick = 1'b1, tx_done = 1'b0, rx_done = 1'b0, abort_btn = 1'b0;
   logic [7:0] rx_data = '0;
   logic tx_req, rx_req, carrier_on, wr_en, busy, done_ok, tag_removed, tag_unknown;
   logic [TXW-1:0] tx_data;
   logic [4:0] tx_bits;
   logic [3:0] rx_bits;
   logic [AW-1:0] wr_addr;
   logic [7:0] wr_data;

   always #2 clk = ~clk;

   tag_read_seq #(
      .TYPE_A(T_A), .TYPE_B(T_B), .SIZE_A(SZ_A), .SIZE_B(SZ_B),
      .CMD_BITS_A(CB_A), .CMD_BITS_B(CB_B), .RESP_A(RM_A), .RESP_B(RM_B),
      .CHARGE_TICKS(CHG), .GAP_TICKS(GAP), .OFF_TICKS(OFF), .TXD_W(TXW)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .tick(tick), .tx_done(tx_done),
      .rx_done(rx_done), .abort_btn(abort_btn), .rx_data(rx_data),
      .tx_req(tx_req), .tx_data(tx_data), .tx_bits(tx_bits), .rx_req(rx_req),
      .rx_bits(rx_bits), .carrier_on(carrier_on), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .busy(busy), .done_ok(done_ok), .tag_removed(tag_removed),
      .tag_unknown(tag_unknown)
   );

   int checks = 0, errors = 0;

   // tag model settings
   logic [5:0] tb_type, tb_type_after;
   int         change_at;
   logic [7:0] tb_mask;
   int         tb_cbits;
   logic [TXW-1:0] last_tx;

   // monitor results
   int cyc, wake_cnt, ack_cnt, frame_err, cmd_err, write_cnt, write_err;
   int min_charge, min_gap, min_off, car_rise, car_fall, rx6_end;
   bit fall_valid, expect_ack, prev_tx, prev_car, prev_rx;
   logic [3:0] prev_rx_bits;

   function automatic logic [7:0] content(int a);
      return 8'(a * 37 + 90);
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // transmitter model
   always begin
      @(negedge clk);
      if (tx_req) begin
         last_tx = tx_data;
         repeat (3) @(negedge clk);
         tx_done = 1'b1;
         @(negedge clk);
         tx_done = 1'b0;
      end
   end

   // receiver and tag model
   always begin
      @(negedge clk);
      if (rx_req) begin
         repeat (4) @(negedge clk);
         if (rx_bits == 4'd6)
            rx_data = {2'b00, (((change_at != 0) && (wake_cnt >= change_at)) ? tb_type_after : tb_type) ^ 6'h26};
         else
            rx_data = content(int'((last_tx ^ TXW'(8'h57)) >> 1)) ^ tb_mask;
         rx_done = 1'b1;
         @(negedge clk);
         rx_done = 1'b0;
      end
   end

   // port monitor
   always @(negedge clk) begin
      cyc++;
      if (carrier_on && !prev_car) begin
         car_rise = cyc;
         if (fall_valid && (cyc - car_fall) < min_off) min_off = cyc - car_fall;
      end
      if (!carrier_on && prev_car) begin
         car_fall   = cyc;
         fall_valid = 1'b1;
      end
      if (prev_rx && !rx_req && prev_rx_bits == 4'd6) begin
         rx6_end    = cyc;
         expect_ack = 1'b1;
      end
      if (tx_req && !prev_tx) begin
         if (expect_ack) begin
            ack_cnt++;
            if (tx_data != TXW'(8'h19) || tx_bits != 5'd6) frame_err++;
            if ((cyc - rx6_end) < min_gap) min_gap = cyc - rx6_end;
            expect_ack = 1'b0;
         end else if (tx_bits == 5'd7 && tx_data == TXW'(8'h55)) begin
            wake_cnt++;
            if ((cyc - car_rise) < min_charge) min_charge = cyc - car_rise;
         end else begin
            if (tx_bits != 5'(tb_cbits) || tx_data != (TXW'(8'h57) ^ TXW'(write_cnt << 1)))
               cmd_err++;
         end
      end
      if (wr_en) begin
         if (int'(wr_addr) != write_cnt || wr_data != content(int'(wr_addr))) write_err++;
         write_cnt++;
      end
      prev_car     = carrier_on;
      prev_tx      = tx_req;
      prev_rx      = rx_req;
      prev_rx_bits = rx_bits;
   end

   task automatic clear_stats();
      wake_cnt = 0; ack_cnt = 0; frame_err = 0; cmd_err = 0;
      write_cnt = 0; write_err = 0; fall_valid = 1'b0; expect_ack = 1'b0;
      min_charge = 1000000; min_gap = 1000000; min_off = 1000000;
   endtask

   task automatic pulse_start();
      @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic wait_idle();
      int n = 0;
      while (busy && n < 30000) begin
         @(negedge clk);
         n++;
      end
      chk(!busy, "R6 run ends (timeout)", int'(busy), 0);
   endtask

   task automatic t_reset();
      chk(!carrier_on && !busy, "R1 reset carrier/busy", int'({carrier_on, busy}), 0);
      chk(!tx_req && !rx_req && !wr_en, "R1 reset requests", int'({tx_req, rx_req, wr_en}), 0);
      chk(!done_ok && !tag_removed && !tag_unknown, "R1 reset flags",
          int'({done_ok, tag_removed, tag_unknown}), 0);
   endtask

   task automatic t_full(input logic [5:0] ty, input int sz, input int cb, input logic [7:0] m);
      tb_type = ty; change_at = 0; tb_mask = m; tb_cbits = cb;
      clear_stats();
      pulse_start();
      wait_idle();
      chk(done_ok, "R6 done_ok", int'(done_ok), 1);
      chk(write_cnt == sz, "R6 byte count", write_cnt, sz);
      chk(write_err == 0, "R6 address/data", write_err, 0);
      chk(cmd_err == 0, "R5 command value/length", cmd_err, 0);
      chk(wake_cnt == sz + 1, "R7 wake frames", wake_cnt, sz + 1);
      chk(ack_cnt == sz + 1 && frame_err == 0, "R3 ack frames", ack_cnt, sz + 1);
      chk(min_charge >= CHG, "R2 charge time", min_charge, CHG);
      chk(min_gap >= GAP, "R3 gap before ack", min_gap, GAP);
      chk(min_off >= OFF, "R7 carrier-off time", min_off, OFF);
      chk(!carrier_on, "R7 carrier off at end", int'(carrier_on), 0);
   endtask

   task automatic t_unknown();
      tb_type = 6'h33; change_at = 0; tb_mask = 8'h00; tb_cbits = 0;
      clear_stats();
      pulse_start();
      wait_idle();
      chk(tag_unknown, "R4 unknown flag", int'(tag_unknown), 1);
      chk(write_cnt == 0, "R4 no writes", write_cnt, 0);
      chk(wake_cnt == 1, "R4 single handshake", wake_cnt, 1);
      chk(!carrier_on && !done_ok, "R4 carrier off, no done", int'({carrier_on, done_ok}), 0);
   endtask

   task automatic t_removed();
      tb_type = T_A; tb_type_after = T_B; change_at = 3; tb_mask = RM_A; tb_cbits = CB_A;
      clear_stats();
      pulse_start();
      wait_idle();
      chk(tag_removed, "R8 removed flag", int'(tag_removed), 1);
      chk(write_cnt == 1 && write_err == 0, "R8 bytes before removal", write_cnt, 1);
      chk(!carrier_on && !done_ok, "R8 carrier off, no done", int'({carrier_on, done_ok}), 0);
   endtask

   task automatic t_abort();
      int n = 0;
      tb_type = T_B; change_at = 0; tb_mask = RM_B; tb_cbits = CB_B;
      clear_stats();
      pulse_start();
      chk(busy && !tag_removed, "R10 start clears flags", int'(tag_removed), 0);
      while (write_cnt == 0 && n < 20000) begin
         @(negedge clk);
         n++;
      end
      abort_btn = 1'b1;
      @(negedge clk);
      abort_btn = 1'b0;
      wait_idle();
      chk(write_cnt == 1 && write_err == 0, "R9 bytes kept after abort", write_cnt, 1);
      chk(!done_ok && !tag_removed && !tag_unknown, "R9 no flag on abort",
          int'({done_ok, tag_removed, tag_unknown}), 0);
      chk(!carrier_on, "R9 carrier off", int'(carrier_on), 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      cyc = 0; prev_tx = 0; prev_car = 0; prev_rx = 0; prev_rx_bits = '0;
      tb_type = T_A; tb_type_after = T_A; change_at = 0; tb_mask = RM_A; tb_cbits = CB_A;
      last_tx = '0;
      clear_stats();
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_reset();
      t_full(T_A, SZ_A, CB_A, RM_A);
      t_full(T_B, SZ_B, CB_B, RM_B);
      t_unknown();
      t_removed();
      t_abort();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule